// File: doc/BRIEF.md
# Program counter next-address unit

This block holds the program counter and the instruction register of a single-cycle 32-bit processor. In every cycle the program counter drives the instruction memory address. The word that memory returns goes to the instruction register. At the clock edge both registers load together: the instruction register takes the fetched word, and the program counter takes the next fetch address chosen by this block.

The next address comes from one of four sources, picked by a 2-bit select:
- a sequential step of one instruction (4 bytes);
- a register-indirect jump that replaces all 32 bits;
- an immediate jump that keeps the upper four PC bits and takes the rest from the current instruction's 26-bit word-address field;
- a PC-relative branch with a signed 16-bit word offset.

A condition-mode input makes any redirect conditional on a flag computed elsewhere. A redirect whose condition is false falls back to the sequential step.

Instruction memory, register reads, comparisons and opcode decoding live outside the block. The select is a combinational choice with four named sources: `SRC_SEQ`, `SRC_REG`, `SRC_JMP` and `SRC_BRN`. The register pair has two named phases: a reset phase that clears both registers, and a run phase that loads both on every edge.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the edge leaves `imem_addr` at 0x00000000 and `ir_out` at 0x00000000, whatever the other inputs are.
- R2: With `src_sel` = 2'b00 (sequential), the edge advances `imem_addr` by 4, wrapping modulo 2^32 (0xFFFFFFFC steps to 0x00000000).
- R3: Every edge out of reset loads `ir_out` with the `instr_in` value present before that edge. This happens on the same edge that loads the new `imem_addr`.
- R4: With `src_sel` = 2'b01 (register jump) taken, the edge loads `imem_addr` with all 32 bits of `reg_val`.
- R5: With `src_sel` = 2'b10 (immediate jump) taken, the new `imem_addr[27:0]` is `ir_out[25:0]` shifted left by two, and `imem_addr[31:28]` keeps its value. The field comes from the instruction register as it was before the edge.
- R6: With `src_sel` = 2'b11 (branch) taken, the new `imem_addr` is the old address + 4 + (`br_off` sign-extended to 32 bits, shifted left by two). Negative offsets are allowed and the result wraps modulo 2^32.
- R7: With `cond_mode` = 1 and `br_cond` = 0, a register jump, immediate jump or branch is not taken, and `imem_addr` advances by 4. With `cond_mode` = 1 and `br_cond` = 1, it is taken.
- R8: With `cond_mode` = 0, every redirect is taken and `br_cond` has no effect on `imem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_in | input | 32 | Word fetched from instruction memory at `imem_addr` |
| reg_val | input | 32 | Register operand used as a register-jump target |
| br_off | input | 16 | Signed branch offset in instruction words |
| br_cond | input | 1 | Condition flag for conditional redirects |
| cond_mode | input | 1 | 1: redirect depends on `br_cond`; 0: unconditional |
| src_sel | input | 2 | Next-address source: 00 sequential, 01 register, 10 immediate, 11 branch |
| imem_addr | output | 32 | Program counter, the instruction fetch address |
| ir_out | output | 32 | Instruction register contents |

## Verification
The immediate jump and the instruction-register load share one edge. The jump reads its word-address field from the instruction register at the same moment that register takes a new word. The bench provokes this by selecting the immediate jump while `instr_in` carries a word with a different field. It judges the result by requiring that the new address uses the old field while `ir_out` shows the new word, and then that a second jump uses the new field. Reset is also asserted together with a register jump, to confirm that the reset phase wins over the redirect.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Next-address source codes; the encoding is visible at the src_sel port.
    typedef enum logic [1:0] {
        SRC_SEQ = 2'b00,
        SRC_REG = 2'b01,
        SRC_JMP = 2'b10,
        SRC_BRN = 2'b11
    } src_e;

    // Phases of the register pair.
    typedef enum logic {
        PH_RESET = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

endpackage

// File: rtl/pcu_targets.sv
module pcu_targets #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int JF_W  = 26,
    parameter int ALIGN = 2
) (
    input  logic [XLEN-1:0]  pc_q,
    input  logic [JF_W-1:0]  jfield,
    input  logic [OFF_W-1:0] br_off,
    output logic [XLEN-1:0]  seq_addr,
    output logic [XLEN-1:0]  brn_addr,
    output logic [XLEN-1:0]  jmp_addr
);
    localparam int KEEP_W = XLEN - JF_W - ALIGN;
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] jmp_low;

    // Sign extension first, then the word-to-byte shift.
    assign off_ext  = {{(XLEN-OFF_W){br_off[OFF_W-1]}}, br_off};
    assign seq_addr = pc_q + STEP;
    assign brn_addr = seq_addr + (off_ext << ALIGN);
    assign jmp_low  = XLEN'(jfield) << ALIGN;

    generate
        if (KEEP_W > 0) begin : g_keep_upper
            assign jmp_addr = {pc_q[XLEN-1 -: KEEP_W], jmp_low[XLEN-KEEP_W-1:0]};
        end else begin : g_full_field
            assign jmp_addr = jmp_low;
        end
    endgenerate

endmodule

// File: rtl/pcu_select.sv
module pcu_select
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  src_e            src,
    input  logic            cond_mode,
    input  logic            br_cond,
    input  logic [XLEN-1:0] seq_addr,
    input  logic [XLEN-1:0] reg_addr,
    input  logic [XLEN-1:0] jmp_addr,
    input  logic [XLEN-1:0] brn_addr,
    output logic [XLEN-1:0] nxt_pc
);
    logic take;

    always_comb begin
        take = !cond_mode || br_cond;
        unique case (src)
            SRC_SEQ: nxt_pc = seq_addr;
            SRC_REG: nxt_pc = take ? reg_addr : seq_addr;
            SRC_JMP: nxt_pc = take ? jmp_addr : seq_addr;
            SRC_BRN: nxt_pc = take ? brn_addr : seq_addr;
            default: nxt_pc = seq_addr;
        endcase
    end

endmodule

// File: rtl/pcu_regs.sv
module pcu_regs
    import pcu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] nxt_pc,
    input  logic [IW-1:0]   instr_in,
    output logic [XLEN-1:0] pc_q,
    output logic [IW-1:0]   ir_q
);
    phase_e phase;

    always_comb begin
        phase = rst ? PH_RESET : PH_RUN;
    end

    // PC and IR always load on the same edge.
    always_ff @(posedge clk) begin
        unique case (phase)
            PH_RESET: begin
                pc_q <= '0;
                ir_q <= '0;
            end
            PH_RUN: begin
                pc_q <= nxt_pc;
                ir_q <= instr_in;
            end
            default: begin
                pc_q <= '0;
                ir_q <= '0;
            end
        endcase
    end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IW    = 32,
    parameter int OFF_W = 16,
    parameter int JF_W  = 26,
    parameter int ALIGN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    instr_in,
    input  logic [XLEN-1:0]  reg_val,
    input  logic [OFF_W-1:0] br_off,
    input  logic             br_cond,
    input  logic             cond_mode,
    input  logic [1:0]       src_sel,
    output logic [XLEN-1:0]  imem_addr,
    output logic [IW-1:0]    ir_out
);
    logic [XLEN-1:0] pc_q;
    logic [IW-1:0]   ir_q;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] brn_addr;
    logic [XLEN-1:0] jmp_addr;
    logic [XLEN-1:0] nxt_pc;
    src_e            src;

    assign src = src_e'(src_sel);

    pcu_targets #(
        .XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W), .ALIGN(ALIGN)
    ) u_targets (
        .pc_q     (pc_q),
        .jfield   (ir_q[JF_W-1:0]),
        .br_off   (br_off),
        .seq_addr (seq_addr),
        .brn_addr (brn_addr),
        .jmp_addr (jmp_addr)
    );

    pcu_select #(
        .XLEN(XLEN)
    ) u_select (
        .src       (src),
        .cond_mode (cond_mode),
        .br_cond   (br_cond),
        .seq_addr  (seq_addr),
        .reg_addr  (reg_val),
        .jmp_addr  (jmp_addr),
        .brn_addr  (brn_addr),
        .nxt_pc    (nxt_pc)
    );

    pcu_regs #(
        .XLEN(XLEN), .IW(IW)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .nxt_pc   (nxt_pc),
        .instr_in (instr_in),
        .pc_q     (pc_q),
        .ir_q     (ir_q)
    );

    assign imem_addr = pc_q;
    assign ir_out    = ir_q;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int XLEN  = 32,
    parameter int IW    = 32,
    parameter int OFF_W = 16,
    parameter int JF_W  = 26,
    parameter int ALIGN = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [IW-1:0]    instr_in,
    input logic [XLEN-1:0]  reg_val,
    input logic [OFF_W-1:0] br_off,
    input logic             br_cond,
    input logic             cond_mode,
    input logic [1:0]       src_sel,
    input logic [XLEN-1:0]  imem_addr,
    input logic [IW-1:0]    ir_out
);
    localparam int LOW_W = JF_W + ALIGN;
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

    logic go;
    assign go = !cond_mode || br_cond;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0) && (ir_out == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00) |=> imem_addr == $past(imem_addr) + STEP);

    p_ir_load_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ir_out == $past(instr_in));

    p_reg_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b01 && go) |=> imem_addr == $past(reg_val));

    p_imm_jump_r5: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b10 && go) |=>
            (imem_addr[LOW_W-1:0] == {$past(ir_out[JF_W-1:0]), {ALIGN{1'b0}}})
            && (imem_addr[XLEN-1:LOW_W] == $past(imem_addr[XLEN-1:LOW_W])));

    p_branch_r6: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b11 && go) |=>
            imem_addr == $past(imem_addr) + STEP
                         + (XLEN'($signed($past(br_off))) << ALIGN));

    p_not_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (cond_mode && !br_cond) |=> imem_addr == $past(imem_addr) + STEP);

endmodule

bind pc_next_unit pcu_checker #(
    .XLEN(XLEN), .IW(IW), .OFF_W(OFF_W), .JF_W(JF_W), .ALIGN(ALIGN)
) u_pcu_checker (
    .clk       (clk),
    .rst       (rst),
    .instr_in  (instr_in),
    .reg_val   (reg_val),
    .br_off    (br_off),
    .br_cond   (br_cond),
    .cond_mode (cond_mode),
    .src_sel   (src_sel),
    .imem_addr (imem_addr),
    .ir_out    (ir_out)
);

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_in = 32'h0;
    logic [31:0] reg_val = 32'h0;
    logic [15:0] br_off = 16'h0;
    logic        br_cond = 1'b0;
    logic        cond_mode = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [31:0] imem_addr;
    logic [31:0] ir_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pc_next_unit dut (
        .clk(clk), .rst(rst), .instr_in(instr_in), .reg_val(reg_val),
        .br_off(br_off), .br_cond(br_cond), .cond_mode(cond_mode),
        .src_sel(src_sel), .imem_addr(imem_addr), .ir_out(ir_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply inputs, pass one rising edge, return 1 ns after it.
    task automatic step(input logic [1:0] s, input logic cm, input logic bc,
                        input logic [31:0] rv, input logic [15:0] off,
                        input logic [31:0] ins);
        src_sel = s; cond_mode = cm; br_cond = bc;
        reg_val = rv; br_off = off; instr_in = ins;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(2'b01, 1'b0, 1'b0, 32'h0000_1234, 16'h0, 32'hDEAD_BEEF);
        chk("R1 pc after reset with reg jump", imem_addr, 32'h0);
        chk("R1 ir after reset", ir_out, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_sequential;
        step(2'b00, 1'b0, 1'b0, 32'h0, 16'h0, 32'h1111_0001);
        chk("R2 first step", imem_addr, 32'h4);
        chk("R3 ir first word", ir_out, 32'h1111_0001);
        step(2'b00, 1'b1, 1'b1, 32'h0, 16'h0, 32'h2222_0002);
        chk("R2 second step", imem_addr, 32'h8);
        chk("R3 ir second word", ir_out, 32'h2222_0002);
    endtask

    task automatic t_reg_jump_wrap;
        step(2'b01, 1'b0, 1'b0, 32'h0000_4400, 16'h0, 32'h0);
        chk("R4 reg jump", imem_addr, 32'h0000_4400);
        step(2'b01, 1'b0, 1'b0, 32'hFFFF_FFFC, 16'h0, 32'h0);
        chk("R4 reg jump top", imem_addr, 32'hFFFF_FFFC);
        step(2'b00, 1'b0, 1'b0, 32'h0, 16'h0, 32'h0);
        chk("R2 wrap to zero", imem_addr, 32'h0);
    endtask

    // Jump field read from the IR being replaced on the same edge.
    task automatic t_imm_jump;
        step(2'b01, 1'b0, 1'b0, 32'hA000_1000, 16'h0, 32'h0800_1100);
        chk("R4 setup", imem_addr, 32'hA000_1000);
        step(2'b10, 1'b0, 1'b0, 32'h0, 16'h0, 32'h0BFF_FFFF);
        chk("R5 jump uses old ir field", imem_addr, 32'hA000_4400);
        chk("R3 ir takes new word on jump edge", ir_out, 32'h0BFF_FFFF);
        step(2'b10, 1'b0, 1'b0, 32'h0, 16'h0, 32'h0);
        chk("R5 jump keeps upper bits", imem_addr, 32'hAFFF_FFFC);
    endtask

    task automatic t_branch;
        step(2'b01, 1'b0, 1'b0, 32'h0000_1000, 16'h0, 32'h0);
        step(2'b11, 1'b0, 1'b0, 32'h0, 16'h0010, 32'h0);
        chk("R6 forward branch", imem_addr, 32'h0000_1044);
        step(2'b11, 1'b0, 1'b0, 32'h0, 16'hFFFF, 32'h0);
        chk("R6 branch minus one word", imem_addr, 32'h0000_1044);
        step(2'b11, 1'b0, 1'b0, 32'h0, 16'h8000, 32'h0);
        chk("R6 most negative branch wraps", imem_addr, 32'hFFFE_1048);
    endtask

    task automatic t_conditional;
        step(2'b01, 1'b0, 1'b0, 32'h0000_2000, 16'h0, 32'h0);
        step(2'b11, 1'b1, 1'b0, 32'h0, 16'h0010, 32'h0);
        chk("R7 branch not taken", imem_addr, 32'h0000_2004);
        step(2'b11, 1'b1, 1'b1, 32'h0, 16'h0010, 32'h0);
        chk("R7 branch taken", imem_addr, 32'h0000_2048);
        step(2'b01, 1'b1, 1'b0, 32'h0000_5000, 16'h0, 32'h0);
        chk("R7 reg jump not taken", imem_addr, 32'h0000_204C);
        step(2'b10, 1'b1, 1'b0, 32'h0, 16'h0, 32'h0);
        chk("R7 imm jump not taken", imem_addr, 32'h0000_2050);
        step(2'b01, 1'b1, 1'b1, 32'h0000_5000, 16'h0, 32'h0);
        chk("R7 reg jump taken", imem_addr, 32'h0000_5000);
    endtask

    task automatic t_unconditional;
        step(2'b11, 1'b0, 1'b0, 32'h0, 16'h0004, 32'h0);
        chk("R8 branch ignores low flag", imem_addr, 32'h0000_5014);
        step(2'b01, 1'b0, 1'b1, 32'h0000_7000, 16'h0, 32'h0);
        chk("R8 reg jump ignores high flag", imem_addr, 32'h0000_7000);
    endtask

    initial begin
        @(posedge clk);
        #1;
        t_reset;
        t_sequential;
        t_reg_jump_wrap;
        t_imm_jump;
        t_branch;
        t_conditional;
        t_unconditional;
        t_reset;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule